// File: doc/BRIEF.md
# Machine Trap Entry and Return Controller

This block sits beside the execute stage of a 32-bit hart that runs in machine or user privilege. Every cycle the pipeline presents at most one operation on a 3-bit opcode. The operation is one of these: an exception, an interrupt, a PC-relative jump or branch, a register-based jump, a machine-return, a user-return, or a write to one of the trap CSRs. One clock later the block has done two things. It has updated the exception PCs, the trap value, the cause and the status stack. It has also raised a redirect with the new fetch address.

Control transfers are screened for alignment. A taken transfer that would land off the 2-byte instruction grid becomes an address-misaligned exception, and it neither writes the link register nor moves the PC. A machine-return issued from user privilege is refused and becomes an illegal-instruction exception. The trap vector base comes in as a plain input, because vectoring lies outside this block.

Top module: `mtrap_unit`

## Requirements
- R1: After reset, privilege is machine (3), the status word reads 0x1800 (previous-privilege field = machine), the saved PCs, trap value and cause read 0, and redirect and link-write are low.
- R2: Opcode 1 (exception) sets the machine saved PC to `pc_i` with bit 0 cleared and the cause to {0, `cause_i`}. It pushes the status stack: previous privilege (bits 12:11) takes the current privilege, previous machine enable (bit 7) takes machine enable (bit 3), and machine enable clears. Privilege becomes machine and the redirect goes to `trap_base_i`. All of this is visible on the outputs one cycle after the request.
- R3: Opcode 2 (interrupt) saves `next_pc_i` with bit 0 cleared, sets the cause to {1, `cause_i`} with bit 31 as the interrupt flag, and leaves the trap value unchanged.
- R4: An exception with cause 0 (misaligned target) stores the faulting `pc_i` as the trap value.
- R5: An exception with cause 2 (illegal instruction) stores all 32 instruction bits as the trap value when bits 1:0 equal 11. Otherwise it stores only bits 15:0, zero-extended.
- R6: An exception with any other cause stores the captured fault data (loaded by `fault_cap_i`) as the trap value. Every exception clears the captured fault data.
- R7: Opcode 3 (PC-relative transfer), when taken with an odd offset, raises cause 0 with the trap value and saved PC equal to `pc_i`, and does not assert link-write. When taken with an even offset, it redirects to `pc_i + offset` and asserts link-write if `xfer_link_i` is set. When not taken, it does nothing.
- R8: Opcode 4 (register transfer) targets `(xfer_base_i + offset)` with bit 0 cleared. It therefore never raises a misalignment trap.
- R9: Opcode 5 (machine-return) from machine privilege takes its privilege from the previous-privilege field and then clears that field to user (0). It also copies previous machine enable into machine enable, sets previous machine enable, and redirects to the machine saved PC.
- R10: Opcode 6 (user-return) sets privilege to user, copies previous user enable (bit 4) into user enable (bit 0), sets previous user enable, and redirects to the user saved PC.
- R11: Opcode 5 issued in user privilege is an illegal-instruction trap (cause 2, trap value per R5 from `insn_i`, saved PC = `pc_i`). The return does not take place.
- R12: Opcode 7 writes the CSR chosen by `csr_sel_i`. Select 0 writes the machine saved PC and select 1 writes the user saved PC, both with bit 0 cleared. Select 2 writes the status word: only bits 0, 3, 4, 7 and 12:11 are kept, and a previous-privilege value other than 11 is stored as 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code (0 idle .. 7 CSR write) |
| cause_i | input | 5 | Exception or interrupt cause |
| pc_i | input | 32 | PC of the current instruction |
| next_pc_i | input | 32 | PC of the following instruction |
| insn_i | input | 32 | Raw instruction bits |
| fault_cap_i | input | 1 | Load the fault-data register |
| fault_data_i | input | 32 | Fault data to capture |
| xfer_taken_i | input | 1 | Transfer is taken |
| xfer_link_i | input | 1 | Transfer writes a link register |
| xfer_base_i | input | 32 | Base register for opcode 4 |
| xfer_offset_i | input | 32 | Sign-extended transfer offset |
| csr_sel_i | input | 2 | CSR chosen by opcode 7 |
| csr_wdata_i | input | 32 | CSR write data |
| trap_base_i | input | 32 | Trap handler address |
| priv_o | output | 2 | Current privilege |
| mstatus_o | output | 32 | Status word |
| mepc_o | output | 32 | Machine saved PC |
| uepc_o | output | 32 | User saved PC |
| mtval_o | output | 32 | Trap value |
| mcause_o | output | 32 | Trap cause |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect address |
| link_we_o | output | 1 | Link register write enable |

## Verification
The bench builds the block with XLEN = 32 and ALIGN_BYTES = 2, which are the defaults. With this alignment, offset parity is the only source of misalignment for PC-relative transfers. Register-based targets can never trap, so the bench checks both that an odd computed target is rounded down and that the transfer proceeds. Odd faulting and next PCs are fed in to exercise the bit-0 masking on both saved PCs. The three instruction-length cases of the illegal-instruction trap value are covered as well.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

  localparam logic [2:0] OP_IDLE = 3'd0;
  localparam logic [2:0] OP_EXC  = 3'd1;
  localparam logic [2:0] OP_IRQ  = 3'd2;
  localparam logic [2:0] OP_JREL = 3'd3;
  localparam logic [2:0] OP_JREG = 3'd4;
  localparam logic [2:0] OP_MRET = 3'd5;
  localparam logic [2:0] OP_URET = 3'd6;
  localparam logic [2:0] OP_CSRW = 3'd7;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] SEL_MEPC   = 2'd0;
  localparam logic [1:0] SEL_UEPC   = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;

  localparam int CAUSE_MISALIGN = 0;
  localparam int CAUSE_ILLEGAL  = 2;

  // status field write bundle
  typedef struct packed {
    logic [1:0] mpp;
    logic       mpie;
    logic       upie;
    logic       mie;
    logic       uie;
  } stat_wr_t;

  // trap value for an illegal instruction: 16-bit form is truncated
  function automatic logic [31:0] illegal_tval(input logic [31:0] insn);
    if (insn[1:0] == 2'b11) return insn;
    return {16'h0000, insn[15:0]};
  endfunction

  // previous-privilege field is legal only as user or machine
  function automatic logic [1:0] legal_mpp(input logic [1:0] v);
    return (v == PRIV_M) ? PRIV_M : PRIV_U;
  endfunction

endpackage

// File: rtl/mtrap_xfer_check.sv
module mtrap_xfer_check #(
  parameter int XLEN        = 32,
  parameter int ALIGN_BYTES = 2
) (
  input  logic            is_reg_based,
  input  logic            taken,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] target,
  output logic            misaligned
);
  localparam logic [XLEN-1:0] LOW_MASK = XLEN'(ALIGN_BYTES - 1);

  logic [XLEN-1:0] sum_reg;
  logic [XLEN-1:0] sum_pc;
  logic [XLEN-1:0] probe;

  always_comb begin
    sum_reg = base + offset;
    sum_pc  = pc + offset;
    target  = is_reg_based ? {sum_reg[XLEN-1:1], 1'b0} : sum_pc;
    probe   = is_reg_based ? target : offset;
    misaligned = taken && ((probe & LOW_MASK) != '0);
  end

endmodule

// File: rtl/mtrap_tval_sel.sv
module mtrap_tval_sel
  import mtrap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic [CAUSE_W-1:0] cause,
  input  logic [XLEN-1:0]    pc,
  input  logic [31:0]        insn,
  input  logic [XLEN-1:0]    fault_q,
  output logic [XLEN-1:0]    tval
);
  always_comb begin
    if (cause == CAUSE_W'(CAUSE_MISALIGN))      tval = pc;
    else if (cause == CAUSE_W'(CAUSE_ILLEGAL))  tval = XLEN'(illegal_tval(insn));
    else                                        tval = fault_q;
  end

  always_comb begin
    if (cause == CAUSE_W'(CAUSE_ILLEGAL) && insn[1:0] != 2'b11)
      assert_short_tval_R5: assert (tval[XLEN-1:16] == '0);
  end

endmodule

// File: rtl/mtrap_status.sv
module mtrap_status
  import mtrap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_trap,
  input  logic            ev_mret,
  input  logic            ev_uret,
  input  logic            ev_write,
  input  stat_wr_t        wr,
  output logic [1:0]      priv,
  output logic [XLEN-1:0] status
);
  logic [1:0] priv_q, mpp_q;
  logic       mie_q, mpie_q, uie_q, upie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv_q <= PRIV_M;
      mpp_q  <= PRIV_M;
      mie_q  <= 1'b0;
      mpie_q <= 1'b0;
      uie_q  <= 1'b0;
      upie_q <= 1'b0;
    end else if (ev_trap) begin
      mpp_q  <= priv_q;
      mpie_q <= mie_q;
      mie_q  <= 1'b0;
      priv_q <= PRIV_M;
    end else if (ev_mret) begin
      priv_q <= mpp_q;
      mpp_q  <= PRIV_U;
      mie_q  <= mpie_q;
      mpie_q <= 1'b1;
    end else if (ev_uret) begin
      priv_q <= PRIV_U;
      uie_q  <= upie_q;
      upie_q <= 1'b1;
    end else if (ev_write) begin
      mpp_q  <= legal_mpp(wr.mpp);
      mpie_q <= wr.mpie;
      upie_q <= wr.upie;
      mie_q  <= wr.mie;
      uie_q  <= wr.uie;
    end
  end

  always_comb begin
    status     = '0;
    status[0]  = uie_q;
    status[3]  = mie_q;
    status[4]  = upie_q;
    status[7]  = mpie_q;
    status[12:11] = mpp_q;
    priv       = priv_q;
  end

  assert_trap_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> (priv_q == PRIV_M) && !mie_q && (mpp_q == $past(priv_q)) && (mpie_q == $past(mie_q)));

  assert_mret_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mret && !ev_trap) |=> (priv_q == $past(mpp_q)) && (mpp_q == PRIV_U) && mpie_q && (mie_q == $past(mpie_q)));

  assert_uret_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_uret && !ev_trap && !ev_mret) |=> (priv_q == PRIV_U) && upie_q && (uie_q == $past(upie_q)));

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
  import mtrap_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int ALIGN_BYTES = 2,
  parameter int CAUSE_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         op_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    next_pc_i,
  input  logic [31:0]        insn_i,
  input  logic               fault_cap_i,
  input  logic [XLEN-1:0]    fault_data_i,
  input  logic               xfer_taken_i,
  input  logic               xfer_link_i,
  input  logic [XLEN-1:0]    xfer_base_i,
  input  logic [XLEN-1:0]    xfer_offset_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic [XLEN-1:0]    trap_base_i,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    mstatus_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    uepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic               link_we_o
);
  localparam logic [XLEN-1:0] LOW_MASK = XLEN'(ALIGN_BYTES - 1);
  localparam logic [XLEN-1:0] PC_MASK  = ~LOW_MASK;
  localparam int              PAD_W    = XLEN - 1 - CAUSE_W;

  // named internal events
  logic               is_xfer, xfer_bad, xret_bad;
  logic               take_exc, take_irq, ev_trap, do_mret, do_uret, do_csrw;
  logic [CAUSE_W-1:0] eff_cause;
  logic [XLEN-1:0]    xfer_target, sel_tval;
  logic               xfer_mis;
  stat_wr_t           stat_wr;

  logic [XLEN-1:0] mepc_q, uepc_q, mtval_q, mcause_q, fault_q, redir_pc_q;
  logic            redir_q, link_q;

  mtrap_xfer_check #(.XLEN(XLEN), .ALIGN_BYTES(ALIGN_BYTES)) u_xfer (
    .is_reg_based (op_i == OP_JREG),
    .taken        (xfer_taken_i),
    .pc           (pc_i),
    .base         (xfer_base_i),
    .offset       (xfer_offset_i),
    .target       (xfer_target),
    .misaligned   (xfer_mis)
  );

  always_comb begin
    is_xfer  = (op_i == OP_JREL) || (op_i == OP_JREG);
    xfer_bad = is_xfer && xfer_mis;
    xret_bad = (op_i == OP_MRET) && (priv_o == PRIV_U);
    take_exc = (op_i == OP_EXC) || xfer_bad || xret_bad;
    take_irq = (op_i == OP_IRQ);
    ev_trap  = take_exc || take_irq;
    do_mret  = (op_i == OP_MRET) && !xret_bad;
    do_uret  = (op_i == OP_URET);
    do_csrw  = (op_i == OP_CSRW);
    if (xfer_bad)      eff_cause = CAUSE_W'(CAUSE_MISALIGN);
    else if (xret_bad) eff_cause = CAUSE_W'(CAUSE_ILLEGAL);
    else               eff_cause = cause_i;
    stat_wr = '{mpp:  csr_wdata_i[12:11], mpie: csr_wdata_i[7],
                upie: csr_wdata_i[4],     mie:  csr_wdata_i[3],
                uie:  csr_wdata_i[0]};
  end

  mtrap_tval_sel #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tval (
    .cause   (eff_cause),
    .pc      (pc_i),
    .insn    (insn_i),
    .fault_q (fault_q),
    .tval    (sel_tval)
  );

  mtrap_status #(.XLEN(XLEN)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_trap  (ev_trap),
    .ev_mret  (do_mret),
    .ev_uret  (do_uret),
    .ev_write (do_csrw && (csr_sel_i == SEL_STATUS)),
    .wr       (stat_wr),
    .priv     (priv_o),
    .status   (mstatus_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mepc_q     <= '0;
      uepc_q     <= '0;
      mtval_q    <= '0;
      mcause_q   <= '0;
      fault_q    <= '0;
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
      link_q     <= 1'b0;
    end else begin
      redir_q <= 1'b0;
      link_q  <= 1'b0;
      if (take_exc) fault_q <= '0;
      else if (fault_cap_i) fault_q <= fault_data_i;

      if (take_exc) begin
        mepc_q     <= pc_i & PC_MASK;
        mtval_q    <= sel_tval;
        mcause_q   <= {1'b0, {PAD_W{1'b0}}, eff_cause};
        redir_q    <= 1'b1;
        redir_pc_q <= trap_base_i;
      end else if (take_irq) begin
        mepc_q     <= next_pc_i & PC_MASK;
        mcause_q   <= {1'b1, {PAD_W{1'b0}}, cause_i};
        redir_q    <= 1'b1;
        redir_pc_q <= trap_base_i;
      end else if (do_mret) begin
        redir_q    <= 1'b1;
        redir_pc_q <= mepc_q;
      end else if (do_uret) begin
        redir_q    <= 1'b1;
        redir_pc_q <= uepc_q;
      end else if (is_xfer && xfer_taken_i) begin
        redir_q    <= 1'b1;
        redir_pc_q <= xfer_target;
        link_q     <= xfer_link_i;
      end else if (do_csrw) begin
        if (csr_sel_i == SEL_MEPC) mepc_q <= csr_wdata_i & PC_MASK;
        if (csr_sel_i == SEL_UEPC) uepc_q <= csr_wdata_i & PC_MASK;
      end
    end
  end

  assign mepc_o        = mepc_q;
  assign uepc_o        = uepc_q;
  assign mtval_o       = mtval_q;
  assign mcause_o      = mcause_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = redir_pc_q;
  assign link_we_o     = link_q;

  assert_epc_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((mepc_o & LOW_MASK) == '0) && ((uepc_o & LOW_MASK) == '0));

  assert_trap_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_trap |=> redirect_o && (redirect_pc_o == $past(trap_base_i)));

  assert_misalign_nolink_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_bad |=> !link_we_o && (mcause_o == '0));

  assert_xret_illegal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xret_bad |=> (mcause_o == XLEN'(CAUSE_ILLEGAL)) && (priv_o == PRIV_M));

  assert_irq_keeps_tval_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> $stable(mtval_o) && mcause_o[XLEN-1]);

  assert_reg_xfer_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_JREG) && xfer_taken_i) |=> redirect_o && !redirect_pc_o[0]);

endmodule

// File: tb/mtrap_unit_tb.sv
module mtrap_unit_tb;
  import mtrap_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = OP_IDLE;
  logic [4:0]  cause_i = '0;
  logic [31:0] pc_i = '0, next_pc_i = '0, insn_i = '0;
  logic        fault_cap_i = 1'b0;
  logic [31:0] fault_data_i = '0;
  logic        xfer_taken_i = 1'b0, xfer_link_i = 1'b0;
  logic [31:0] xfer_base_i = '0, xfer_offset_i = '0;
  logic [1:0]  csr_sel_i = '0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] trap_base_i = 32'h8000_0100;
  logic [1:0]  priv_o;
  logic [31:0] mstatus_o, mepc_o, uepc_o, mtval_o, mcause_o, redirect_pc_o;
  logic        redirect_o, link_we_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mtrap_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .cause_i(cause_i), .pc_i(pc_i),
    .next_pc_i(next_pc_i), .insn_i(insn_i), .fault_cap_i(fault_cap_i),
    .fault_data_i(fault_data_i), .xfer_taken_i(xfer_taken_i),
    .xfer_link_i(xfer_link_i), .xfer_base_i(xfer_base_i),
    .xfer_offset_i(xfer_offset_i), .csr_sel_i(csr_sel_i),
    .csr_wdata_i(csr_wdata_i), .trap_base_i(trap_base_i), .priv_o(priv_o),
    .mstatus_o(mstatus_o), .mepc_o(mepc_o), .uepc_o(uepc_o), .mtval_o(mtval_o),
    .mcause_o(mcause_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .link_we_o(link_we_o)
  );

  typedef struct packed {
    logic [4:0]  cause;
    logic [31:0] pc;
    logic [31:0] insn;
    logic [31:0] tval;
    logic [31:0] epc;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 32'h0000_1003, 32'h0000_0000, 32'h0000_1003, 32'h0000_1002},
    '{5'd2, 32'h0000_2000, 32'h00A5_0533, 32'h00A5_0533, 32'h0000_2000},
    '{5'd2, 32'h0000_2004, 32'hDEAD_4501, 32'h0000_4501, 32'h0000_2004},
    '{5'd2, 32'h0000_2008, 32'h1234_FFFE, 32'h0000_FFFE, 32'h0000_2008},
    '{5'd5, 32'h0000_3000, 32'h0000_0000, 32'h0000_0000, 32'h0000_3000},
    '{5'd7, 32'h0000_3005, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_3004}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive op for one cycle; outputs are sampled at the following negedge
  task automatic issue(input logic [2:0] op);
    @(negedge clk);
    op_i = op;
    @(negedge clk);
    op_i = OP_IDLE;
  endtask

  task automatic csr_write(input logic [1:0] sel, input logic [31:0] v);
    csr_sel_i = sel;
    csr_wdata_i = v;
    issue(OP_CSRW);
  endtask

  task automatic xfer(input logic [2:0] op, input logic tk, input logic lk,
                      input logic [31:0] pc, input logic [31:0] base, input logic [31:0] off);
    xfer_taken_i = tk; xfer_link_i = lk; pc_i = pc; xfer_base_i = base; xfer_offset_i = off;
    issue(op);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 priv", {30'd0, priv_o}, 32'd3);
    chk("R1 status", mstatus_o, 32'h0000_1800);
    chk("R1 mepc", mepc_o, 32'h0);
    chk("R1 mtval", mtval_o, 32'h0);
    chk("R1 mcause", mcause_o, 32'h0);
    chk("R1 redirect", {31'd0, redirect_o}, 32'd0);

    // R4 R5 R6 table of exceptions
    for (int i = 0; i < NV; i++) begin
      cause_i = VECS[i].cause;
      pc_i    = VECS[i].pc;
      insn_i  = VECS[i].insn;
      issue(OP_EXC);
      chk("R4/R5/R6 mtval", mtval_o, VECS[i].tval);
      chk("R2 mepc", mepc_o, VECS[i].epc);
      chk("R2 mcause", mcause_o, {27'd0, VECS[i].cause});
      chk("R2 redirect", {redirect_o, redirect_pc_o[30:0]}, {1'b1, trap_base_i[30:0]});
      chk("R2 priv", {30'd0, priv_o}, 32'd3);
    end

    // R6 captured fault data, then cleared
    @(negedge clk); fault_data_i = 32'hCAFE_F00D; fault_cap_i = 1'b1;
    @(negedge clk); fault_cap_i = 1'b0;
    cause_i = 5'd5; pc_i = 32'h3100;
    issue(OP_EXC);
    chk("R6 fault tval", mtval_o, 32'hCAFE_F00D);
    cause_i = 5'd13;
    issue(OP_EXC);
    chk("R6 cleared", mtval_o, 32'h0);

    // R2 status stack push
    csr_write(SEL_STATUS, 32'h0000_1808);
    chk("R12 status write", mstatus_o, 32'h0000_1808);
    cause_i = 5'd11;
    issue(OP_EXC);
    chk("R2 stack push", mstatus_o, 32'h0000_1880);

    // R3 interrupt
    cause_i = 5'd2; pc_i = 32'h4000; insn_i = 32'hDEAD_4501;
    issue(OP_EXC);
    cause_i = 5'd7; next_pc_i = 32'h0000_4445;
    issue(OP_IRQ);
    chk("R3 mepc", mepc_o, 32'h0000_4444);
    chk("R3 mcause", mcause_o, 32'h8000_0007);
    chk("R3 mtval kept", mtval_o, 32'h0000_4501);

    // R12 CSR writes
    csr_write(SEL_MEPC, 32'h1234_5679);
    chk("R12 mepc", mepc_o, 32'h1234_5678);
    csr_write(SEL_UEPC, 32'h0000_0201);
    chk("R12 uepc", uepc_o, 32'h0000_0200);
    csr_write(SEL_STATUS, 32'hFFFF_FFFF);
    chk("R12 status mask", mstatus_o, 32'h0000_1899);
    csr_write(SEL_STATUS, 32'h0000_1000);
    chk("R12 mpp legal", mstatus_o, 32'h0000_0000);

    // R9 machine-return into user
    csr_write(SEL_STATUS, 32'h0000_0080);
    issue(OP_MRET);
    chk("R9 priv", {30'd0, priv_o}, 32'd0);
    chk("R9 status", mstatus_o, 32'h0000_0088);
    chk("R9 redirect", redirect_pc_o, 32'h1234_5678);
    chk("R9 redirect valid", {31'd0, redirect_o}, 32'd1);

    // R10 user-return
    csr_write(SEL_STATUS, 32'h0000_0010);
    issue(OP_URET);
    chk("R10 priv", {30'd0, priv_o}, 32'd0);
    chk("R10 status", mstatus_o, 32'h0000_0011);
    chk("R10 redirect", redirect_pc_o, 32'h0000_0200);

    // R11 machine-return from user is illegal
    insn_i = 32'h3020_0073; pc_i = 32'h5000;
    issue(OP_MRET);
    chk("R11 mcause", mcause_o, 32'd2);
    chk("R11 mtval", mtval_o, 32'h3020_0073);
    chk("R11 mepc", mepc_o, 32'h0000_5000);
    chk("R11 priv", {30'd0, priv_o}, 32'd3);
    chk("R11 status", mstatus_o, 32'h0000_0011);
    chk("R11 redirect", redirect_pc_o, trap_base_i);

    // R7 PC-relative transfers
    xfer(OP_JREL, 1'b1, 1'b1, 32'h6000, 32'h0, 32'h11);
    chk("R7 misalign cause", mcause_o, 32'd0);
    chk("R7 misalign tval", mtval_o, 32'h6000);
    chk("R7 misalign mepc", mepc_o, 32'h6000);
    chk("R7 misalign nolink", {31'd0, link_we_o}, 32'd0);
    chk("R7 misalign redirect", redirect_pc_o, trap_base_i);
    xfer(OP_JREL, 1'b1, 1'b1, 32'h6000, 32'h0, 32'h20);
    chk("R7 jump target", redirect_pc_o, 32'h6020);
    chk("R7 jump link", {31'd0, link_we_o}, 32'd1);
    chk("R7 jump no trap", mepc_o, 32'h6000);
    xfer(OP_JREL, 1'b0, 1'b0, 32'h6100, 32'h0, 32'h7);
    chk("R7 not taken", {31'd0, redirect_o}, 32'd0);
    chk("R7 not taken mepc", mepc_o, 32'h6000);
    xfer(OP_JREL, 1'b1, 1'b0, 32'h6000, 32'h0, 32'hFFFF_FFFC);
    chk("R7 back branch", redirect_pc_o, 32'h5FFC);

    // R8 register transfers
    xfer(OP_JREG, 1'b1, 1'b1, 32'h6200, 32'h7001, 32'h2);
    chk("R8 target", redirect_pc_o, 32'h7002);
    chk("R8 link", {31'd0, link_we_o}, 32'd1);
    chk("R8 no trap", mepc_o, 32'h6000);
    xfer(OP_JREG, 1'b1, 1'b0, 32'h6200, 32'h7000, 32'h3);
    chk("R8 odd sum", redirect_pc_o, 32'h7002);
    chk("R8 odd sum no trap", mcause_o, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule